// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a 4 KB window of 32-bit control and status registers that sits on a simple word-wide read/write request bus. The bus uses byte offsets. It holds a representative set of system settings: PLL control and status, clock control, peripheral reset control, DRAM controller settings, pin configuration, and I/O bank settings. Each of these registers has its own reset value. The clock, PLL and reset side effects that these settings would drive in a full chip are not part of this block.

Most of the register space is write-protected. A write only lands after software has written a 16-bit unlock key to a dedicated offset. A second key puts the protection back. A status offset reports whether the bank is protected. A single-bit scratch register at offset 0x0 can always be written.

The offset decoder does four things. It computes the index inside each range as (offset − base)/4. It never indexes past the end of a range. It treats any offset whose two low bits are not zero as unmapped. It returns zero for reads of offsets that have no register behind them.

Top module: `keyed_ctrl_bank`

## Requirements
- R1: After reset the bank is locked, and reading offset 0xC returns 1.
- R2: A write to offset 0x4 whose data bits [15:0] equal 0x767B locks the bank. A write there with any other value leaves the lock state unchanged.
- R3: A write to offset 0x8 whose data bits [15:0] equal 0xDF0D unlocks the bank. A write there with any other value leaves the lock state unchanged.
- R4: Reading offset 0xC returns the lock state in bit 0 (1 = locked) and zero in the other bits. Writes to 0xC change nothing.
- R5: Reads of offsets 0x4 and 0x8 always return zero.
- R6: Offset 0x0 stores only bit 0 of the written data, reads it back in bit 0 with the other bits zero, and accepts writes whether the bank is locked or not.
- R7: While the bank is locked, writes to any offset other than 0x0, 0x4 and 0x8 leave every register unchanged.
- R8: Offsets 0x10C, 0x250, 0x604, 0xB20 and 0xB2C keep their contents even when the bank is unlocked. Offset 0x604 always reads zero.
- R9: Reset values are as follows:
  - 0x100, 0x104 and 0x108 reset to 0x0001A008.
  - 0x10C resets to 0x0000003F.
  - 0x110, 0x114 and 0x118 reset to 0x00014000.
  - In the pin range, 0x708 to 0x720 reset to 0x00000601, and the other pin offsets from 0x700 to 0x7D4 reset to 0x00001601.
- R10: Offset 0x25C always reads the constant 1, and writes to it have no effect.
- R11: Reads return zero, and writes have no effect, for any offset that has no register behind it. This includes any offset with bits [1:0] not zero and the word just past the end of a range (for example 0x7D8).
- R12: A read request returns its data with rd_valid high exactly one cycle after the request. rd_valid is low in every other cycle.
- R13: When the bank is unlocked, a writable register returns the last value written to it. This includes the last word of a range (0x16C, 0x7D4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the 4 KB window |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 32 | Registered read data |

## Verification
Both a write and a lock-key update take effect at the clock edge that accepts the request. A read issued in any later cycle must therefore see the new value. Read data and rd_valid come from registers and are due one cycle after the read request. The bench drives each request on the falling edge. It samples the result on the next falling edge, which is after the edge that served the request. Every "has no effect" requirement is checked by reading the affected offset back after the rejected write.

// File: rtl/keyed_ctrl_bank_pkg.sv
package keyed_ctrl_bank_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;
  localparam int NGRP   = 6;

  localparam logic [15:0] KEY_LOCK   = 16'h767B;
  localparam logic [15:0] KEY_UNLOCK = 16'hDF0D;

  localparam logic [ADDR_W-1:0] OFS_SCRATCH = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_LOCK    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_UNLOCK  = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_ONE     = 12'h25C;

  // Range table: pll, clock, reset, dram, pin, io bank
  localparam logic [ADDR_W-1:0] GRP_BASE [NGRP] =
    '{12'h100, 12'h120, 12'h200, 12'h600, 12'h700, 12'hB00};
  localparam int GRP_LEN [NGRP] = '{8, 20, 23, 9, 54, 12};

  function automatic logic [DATA_W-1:0] grp_reset(input int g, input int i);
    logic [DATA_W-1:0] v;
    v = '0;
    case (g)
      0: begin
        if (i < 3)      v = 32'h0001_A008;
        else if (i == 3) v = 32'h0000_003F;
        else if (i < 7)  v = 32'h0001_4000;
      end
      1: begin
        if (i == 0)      v = 32'h1F00_0400;
        else if (i == 1) v = 32'h1840_0003;
        else if (i >= 8) v = 32'h0000_3C01;
      end
      2: begin
        if (i == 15)      v = 32'h01F3_3F0F;
        else if (i == 18) v = 32'h0000_0040;
      end
      4: v = (i >= 2 && i <= 8) ? 32'h0000_0601 : 32'h0000_1601;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic bit grp_reject(input int g, input int i);
    return (g == 0 && i == 3) || (g == 2 && i == 20) || (g == 3 && i == 1) ||
           (g == 5 && (i == 8 || i == 11));
  endfunction

  function automatic bit grp_rdzero(input int g, input int i);
    return (g == 3 && i == 1);
  endfunction
endpackage

// File: rtl/keyed_ctrl_bank_lock.sv
module keyed_ctrl_bank_lock
  import keyed_ctrl_bank_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_we,
  input  logic          unlock_we,
  input  logic [DW-1:0] wdata,
  output logic          locked
);
  logic [15:0] key;
  assign key = wdata[15:0];

  always_ff @(posedge clk) begin
    if (rst)
      locked <= 1'b1;
    else if (lock_we && key == KEY_LOCK)
      locked <= 1'b1;
    else if (unlock_we && key == KEY_UNLOCK)
      locked <= 1'b0;
  end
endmodule

// File: rtl/keyed_ctrl_bank_decode.sv
module keyed_ctrl_bank_decode
  import keyed_ctrl_bank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W
) (
  input  logic [AW-1:0]   addr,
  output logic [NGRP-1:0] hit,
  output logic [IW-1:0]   idx
);
  always_comb begin
    hit = '0;
    idx = '0;
    for (int g = 0; g < NGRP; g++) begin
      logic [AW-1:0] off;
      off = addr - GRP_BASE[g];
      if (addr[1:0] == 2'b00 && addr >= GRP_BASE[g] &&
          int'(off[AW-1:2]) < GRP_LEN[g]) begin
        hit[g] = 1'b1;
        idx    = idx | off[IW+1:2];
      end
    end
  end
endmodule

// File: rtl/keyed_ctrl_bank_group.sv
module keyed_ctrl_bank_group
  import keyed_ctrl_bank_pkg::*;
#(
  parameter int GID = 0,
  parameter int LEN = 8,
  parameter int DW  = DATA_W,
  parameter int IW  = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] regs [LEN];

  for (genvar i = 0; i < LEN; i++) begin : g_reg
    localparam logic [DW-1:0] RV = grp_reset(GID, i);
    localparam bit            RJ = grp_reject(GID, i);
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= RV;
      else if (wr_en && !RJ && idx == IW'(i))
        regs[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < LEN; i++)
      if (idx == IW'(i) && !grp_rdzero(GID, i))
        rdata = regs[i];
  end
endmodule

// File: rtl/keyed_ctrl_bank.sv
module keyed_ctrl_bank
  import keyed_ctrl_bank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int IW = IDX_W;

  logic            wr, rd;
  logic            locked;
  logic            scl_q;
  logic [NGRP-1:0] hit;
  logic [IW-1:0]   idx;
  logic [DW-1:0]   grp_rd [NGRP];
  logic [DW-1:0]   rd_next;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;

  keyed_ctrl_bank_lock #(.DW(DW)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .lock_we   (wr && req_addr == OFS_LOCK),
    .unlock_we (wr && req_addr == OFS_UNLOCK),
    .wdata     (req_wdata),
    .locked    (locked)
  );

  keyed_ctrl_bank_decode #(.AW(AW), .IW(IW)) u_dec (
    .addr (req_addr),
    .hit  (hit),
    .idx  (idx)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    keyed_ctrl_bank_group #(
      .GID (g),
      .LEN (GRP_LEN[g]),
      .DW  (DW),
      .IW  (IW)
    ) u_grp (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr && !locked && hit[g]),
      .idx   (idx),
      .wdata (req_wdata),
      .rdata (grp_rd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      scl_q <= 1'b0;
    else if (wr && req_addr == OFS_SCRATCH)
      scl_q <= req_wdata[0];
  end

  always_comb begin
    rd_next = '0;
    case (req_addr)
      OFS_SCRATCH: rd_next = DW'(scl_q);
      OFS_STATUS:  rd_next = DW'(locked);
      OFS_ONE:     rd_next = DW'(1);
      default: begin
        for (int g = 0; g < NGRP; g++)
          if (hit[g]) rd_next = rd_next | grp_rd[g];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd;
      rd_data  <= rd ? rd_next : '0;
    end
  end
endmodule

// File: rtl/keyed_ctrl_bank_checker.sv
module keyed_ctrl_bank_checker #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          locked,
  input logic          scl_q
);
  logic rdq, wrq;
  assign rdq = req_valid && !req_write;
  assign wrq = req_valid && req_write;

  assert_locked_after_reset_R1: assert property (@(posedge clk)
    !rst && $past(rst) |-> locked);

  assert_lock_key_R2: assert property (@(posedge clk) disable iff (rst)
    wrq && req_addr == 12'h004 && req_wdata[15:0] == 16'h767B |=> locked);

  assert_unlock_key_R3: assert property (@(posedge clk) disable iff (rst)
    wrq && req_addr == 12'h008 && req_wdata[15:0] == 16'hDF0D |=> !locked);

  assert_status_read_R4: assert property (@(posedge clk) disable iff (rst)
    rdq && req_addr == 12'h00C |=> rd_data == DW'($past(locked)));

  assert_key_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rdq && (req_addr == 12'h004 || req_addr == 12'h008) |=> rd_data == '0);

  assert_scratch_write_R6: assert property (@(posedge clk) disable iff (rst)
    wrq && req_addr == 12'h000 |=> scl_q == $past(req_wdata[0]));

  assert_const_one_R10: assert property (@(posedge clk) disable iff (rst)
    rdq && req_addr == 12'h25C |=> rd_data == DW'(1));

  assert_misaligned_zero_R11: assert property (@(posedge clk) disable iff (rst)
    rdq && req_addr[1:0] != 2'b00 |=> rd_data == '0);

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (rst)
    rdq |=> rd_valid);

  assert_no_spurious_valid_R12: assert property (@(posedge clk) disable iff (rst)
    !rdq |=> !rd_valid);
endmodule

bind keyed_ctrl_bank keyed_ctrl_bank_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .locked    (locked),
  .scl_q     (scl_q)
);

// File: tb/tb_keyed_ctrl_bank.sv
module tb_keyed_ctrl_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr  = '0;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  keyed_ctrl_bank dut (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rd_data;
    check("R12 rd_valid with data", {31'b0, rd_valid}, 32'd1);
    req_valid = 1'b0;
  endtask

  task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset_state;
    expect_rd("R1 status after reset", 12'h00C, 32'd1);
    expect_rd("R9 pll ctrl 0x100", 12'h100, 32'h0001A008);
    expect_rd("R9 pll ctrl 0x108", 12'h108, 32'h0001A008);
    expect_rd("R9 pll status", 12'h10C, 32'h0000003F);
    expect_rd("R9 pll cfg 0x110", 12'h110, 32'h00014000);
    expect_rd("R9 pll cfg 0x118", 12'h118, 32'h00014000);
    expect_rd("R9 pin 0x700", 12'h700, 32'h00001601);
    expect_rd("R9 pin 0x708", 12'h708, 32'h00000601);
    expect_rd("R9 pin 0x720", 12'h720, 32'h00000601);
    expect_rd("R9 pin 0x724", 12'h724, 32'h00001601);
  endtask

  task automatic t_latency;
    @(negedge clk);
    check("R12 idle rd_valid", {31'b0, rd_valid}, 32'd0);
  endtask

  task automatic t_locked_writes;
    bus_write(12'h100, 32'hDEADBEEF);
    expect_rd("R7 locked pll write", 12'h100, 32'h0001A008);
    bus_write(12'h7D4, 32'h12345678);
    expect_rd("R7 locked pin write", 12'h7D4, 32'h00001601);
    bus_write(12'h000, 32'hFFFFFFFF);
    expect_rd("R6 scratch locked write", 12'h000, 32'd1);
    bus_write(12'h000, 32'hFFFFFFFE);
    expect_rd("R6 scratch bit0 only", 12'h000, 32'd0);
  endtask

  task automatic t_keys;
    bus_write(12'h008, 32'h0000DF0E);
    expect_rd("R3 wrong unlock key", 12'h00C, 32'd1);
    bus_write(12'h008, 32'hABCDDF0D);
    expect_rd("R3 unlock key", 12'h00C, 32'd0);
    bus_write(12'h00C, 32'h00000001);
    expect_rd("R4 status write ignored", 12'h00C, 32'd0);
    bus_write(12'h004, 32'h0000767C);
    expect_rd("R2 wrong lock key", 12'h00C, 32'd0);
    expect_rd("R5 lock offset reads zero", 12'h004, 32'd0);
    expect_rd("R5 unlock offset reads zero", 12'h008, 32'd0);
  endtask

  task automatic t_unlocked_rw;
    bus_write(12'h100, 32'hCAFE0001);
    expect_rd("R13 pll ctrl write", 12'h100, 32'hCAFE0001);
    bus_write(12'h16C, 32'h5A5A5A5A);
    expect_rd("R13 clock last word", 12'h16C, 32'h5A5A5A5A);
    bus_write(12'h7D4, 32'hA5A50F0F);
    expect_rd("R13 pin last word", 12'h7D4, 32'hA5A50F0F);
    expect_rd("R13 pin neighbour intact", 12'h7D0, 32'h00001601);
  endtask

  task automatic t_rejected;
    bus_write(12'h10C, 32'h00000000);
    expect_rd("R8 pll status kept", 12'h10C, 32'h0000003F);
    bus_write(12'h250, 32'h11111111);
    expect_rd("R8 0x250 kept", 12'h250, 32'd0);
    bus_write(12'h604, 32'h22222222);
    expect_rd("R8 0x604 reads zero", 12'h604, 32'd0);
    bus_write(12'hB20, 32'h33333333);
    expect_rd("R8 0xB20 kept", 12'hB20, 32'd0);
    bus_write(12'hB2C, 32'h44444444);
    expect_rd("R8 0xB2C kept", 12'hB2C, 32'd0);
    bus_write(12'hB28, 32'h55555555);
    expect_rd("R13 io bank writable", 12'hB28, 32'h55555555);
  endtask

  task automatic t_special_unmapped;
    bus_write(12'h25C, 32'h00000000);
    expect_rd("R10 constant one", 12'h25C, 32'd1);
    bus_write(12'h7D8, 32'h66666666);
    expect_rd("R11 past pin range", 12'h7D8, 32'd0);
    bus_write(12'h101, 32'h77777777);
    expect_rd("R11 misaligned read", 12'h101, 32'd0);
    expect_rd("R11 misaligned write ignored", 12'h100, 32'hCAFE0001);
    expect_rd("R11 hole 0x300", 12'h300, 32'd0);
  endtask

  task automatic t_relock;
    bus_write(12'h004, 32'h0000767B);
    expect_rd("R2 lock key", 12'h00C, 32'd1);
    bus_write(12'h16C, 32'h00000000);
    expect_rd("R7 relocked write dropped", 12'h16C, 32'h5A5A5A5A);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_latency();
    t_locked_writes();
    t_keys();
    t_unlocked_rw();
    t_rejected();
    t_special_unmapped();
    t_relock();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule